// File: doc/BRIEF.md
# Enable Input Qualifier with Sleep Control

This block turns an enable line from outside the clock domain into a clean control level. The line goes through a synchronizer and then a filter. The filter does not accept a high pulse until the line has stayed high for `RISE_CYC` clocks. It does not accept a low pulse until the line has stayed low for `FALL_CYC` clocks. Because the two widths are separate, each direction can be made as tolerant of glitches as it needs to be.

From the qualified level the block derives three outputs, all registered:

- a sleep request, high whenever the qualified level is low. A downstream switch controller uses it to hold the pass switch open.
- a one-clock clear pulse on every accepted rising edge. Fault-handling logic uses it to erase its stored measurement history and leave any latched overcharge, overdischarge or overcurrent state.
- a one-clock bypass-drop pulse on every accepted falling edge. It tells the bypass path to turn off.

Top module: `enable_qualifier`

## Requirements
- R1: While `rst_i` is high, and on the first clock after it, `en_o`=0, `sleep_o`=1, `clr_o`=0 and `byp_drop_o`=0.
- R2: A high level on `en_raw_i` lasting fewer than `RISE_CYC` clocks leaves `en_o` low and produces no `clr_o` pulse.
- R3: A high level on `en_raw_i` lasting at least `RISE_CYC` clocks drives `en_o` high. This happens exactly `RISE_CYC`+3 rising clock edges after the first edge that samples the raw line high.
- R4: A low level on `en_raw_i` lasting fewer than `FALL_CYC` clocks leaves `en_o` high and produces no `byp_drop_o` pulse.
- R5: A low level on `en_raw_i` lasting at least `FALL_CYC` clocks drives `en_o` low. This happens exactly `FALL_CYC`+3 rising edges after the first edge that samples the raw line low.
- R6: `clr_o` is high for exactly one clock on each low-to-high change of `en_o`, in the same cycle in which `en_o` first reads 1. It is never high at any other time.
- R7: `sleep_o` equals the inverse of `en_o` in every cycle.
- R8: `byp_drop_o` is high for exactly one clock on each high-to-low change of `en_o`, in the same cycle in which `en_o` first reads 0. It is never high at any other time.
- R9: After a reset, `en_o` stays low even if `en_raw_i` is already high. It rises only once a full `RISE_CYC` high has been seen after reset, at the same latency as R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_raw_i | input | 1 | Asynchronous enable line |
| en_o | output | 1 | Qualified enable level |
| clr_o | output | 1 | One-clock clear pulse on each accepted rise |
| sleep_o | output | 1 | Sleep request, high while qualified enable is low |
| byp_drop_o | output | 1 | One-clock bypass-off pulse on each accepted fall |

## Verification
A qualifying edge on the raw line reaches `en_o` after the hold width plus three registers: two synchronizer stages and the output register. The filter flop updates on the last counted edge, and the output register follows one clock later. `clr_o`, `byp_drop_o` and `sleep_o` come from that same output register, so they change in the same cycle as `en_o`.

The bench changes the raw line on falling edges and samples outputs just after falling edges. Pulse counters accumulate on every falling edge. Each vector's expected level and pulse totals are checked after segments long enough for the full latency to have elapsed. Two directed tests sample one cycle before and at the exact `RISE_CYC`+3 and `FALL_CYC`+3 edges.

// File: rtl/enq_pkg.sv
package enq_pkg;
  // Registered view of the qualified enable and its edge strobes.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } enq_evt_t;

  function automatic int enq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/enq_sync.sv
module enq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain[g] <= 1'b0;
          else       chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/enq_filter.sv
module enq_filter
  import enq_pkg::*;
#(
  parameter int RISE_CYC = 300,
  parameter int FALL_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic s_i,
  output logic lvl_o
);
  localparam int MAXC = enq_max(RISE_CYC, FALL_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

  logic          lvl_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] last;

  // Width needed depends on which way the level would move.
  always_comb last = lvl_q ? FALL_LAST : RISE_LAST;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (s_i != lvl_q) begin
      if (run_q == last) begin
        lvl_q <= s_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/enq_outreg.sv
module enq_outreg
  import enq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     lvl_i,
  output enq_evt_t evt_o,
  output logic     sleep_o
);
  enq_evt_t evt_q;
  logic     sleep_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      evt_q   <= '0;
      sleep_q <= 1'b1;
    end else begin
      evt_q.lvl  <= lvl_i;
      evt_q.rise <= lvl_i & ~evt_q.lvl;
      evt_q.fall <= ~lvl_i & evt_q.lvl;
      sleep_q    <= ~lvl_i;
    end
  end

  assign evt_o   = evt_q;
  assign sleep_o = sleep_q;
endmodule

// File: rtl/enable_qualifier.sv
module enable_qualifier
  import enq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RISE_CYC    = 300,
  parameter int FALL_CYC    = 500
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_raw_i,
  output logic en_o,
  output logic clr_o,
  output logic sleep_o,
  output logic byp_drop_o
);
  logic     en_sync;
  logic     en_filt;
  enq_evt_t evt;

  enq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (en_raw_i),
    .q_o   (en_sync)
  );

  enq_filter #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_filt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .s_i   (en_sync),
    .lvl_o (en_filt)
  );

  enq_outreg u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .lvl_i   (en_filt),
    .evt_o   (evt),
    .sleep_o (sleep_o)
  );

  assign en_o       = evt.lvl;
  assign clr_o      = evt.rise;
  assign byp_drop_o = evt.fall;
endmodule

// File: rtl/enable_qualifier_chk.sv
module enable_qualifier_chk (
  input logic clk_i,
  input logic rst_i,
  input logic en_o,
  input logic clr_o,
  input logic sleep_o,
  input logic byp_drop_o
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk_i)
    rst_i |=> (!en_o && sleep_o && !clr_o && !byp_drop_o));

  // R6
  a_r6_clr_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(en_o) |-> clr_o);
  a_r6_clr_only_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_o |-> (en_o && !$past(en_o)));
  a_r6_clr_single: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_o |=> !clr_o);

  // R7
  a_r7_sleep_inverse: assert property (@(posedge clk_i) disable iff (rst_i)
    sleep_o == !en_o);

  // R8
  a_r8_drop_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(en_o) |-> byp_drop_o);
  a_r8_drop_only_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    byp_drop_o |-> (!en_o && $past(en_o)));
  a_r8_drop_single: assert property (@(posedge clk_i) disable iff (rst_i)
    byp_drop_o |=> !byp_drop_o);
endmodule

bind enable_qualifier enable_qualifier_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .en_o       (en_o),
  .clr_o      (clr_o),
  .sleep_o    (sleep_o),
  .byp_drop_o (byp_drop_o)
);

// File: tb/enable_qualifier_tb.sv
module enable_qualifier_tb;
  localparam int RISE = 12;
  localparam int FALL = 20;
  localparam int NV   = 11;

  typedef struct packed {
    logic       lvl;
    logic [7:0] cyc;
    logic       en;
    logic [3:0] nclr;
    logic [3:0] ndrop;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd30, 1'b0, 4'd0, 4'd0},  // R1 idle low
    '{1'b1, 8'd11, 1'b0, 4'd0, 4'd0},  // R2 short high
    '{1'b0, 8'd30, 1'b0, 4'd0, 4'd0},  // R2 still low, no clr
    '{1'b1, 8'd12, 1'b0, 4'd0, 4'd0},  // R3 exact width, not yet out
    '{1'b0, 8'd40, 1'b0, 4'd1, 4'd1},  // R3 accepted, R5 fall later
    '{1'b1, 8'd40, 1'b1, 4'd2, 4'd1},  // R3 R6
    '{1'b0, 8'd19, 1'b1, 4'd2, 4'd1},  // R4 short low
    '{1'b1, 8'd30, 1'b1, 4'd2, 4'd1},  // R4 no drop, no extra clr
    '{1'b0, 8'd20, 1'b1, 4'd2, 4'd1},  // R5 exact low width
    '{1'b1, 8'd40, 1'b1, 4'd3, 4'd2},  // R5 R8 then R3 again
    '{1'b0, 8'd40, 1'b0, 4'd3, 4'd3}   // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic en, clr, slp, drp;

  int checks = 0;
  int fails  = 0;
  int nclr   = 0;
  int ndrop  = 0;
  logic prev_clr = 1'b0;
  logic prev_drp = 1'b0;

  always #5 clk = ~clk;

  enable_qualifier #(.SYNC_STAGES(2), .RISE_CYC(RISE), .FALL_CYC(FALL)) u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .en_raw_i   (raw),
    .en_o       (en),
    .clr_o      (clr),
    .sleep_o    (slp),
    .byp_drop_o (drp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse monitor: counts strobes and flags any wider than one clock (R6, R8).
  always @(negedge clk) begin
    if (!rst) begin
      if (clr) nclr++;
      if (drp) ndrop++;
      if (clr && prev_clr) chk("R6 clr width", 2, 1);
      if (drp && prev_drp) chk("R8 drop width", 2, 1);
    end
    prev_clr = clr;
    prev_drp = drp;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    cycles(3);
    chk("R1 en", en, 0);
    chk("R1 sleep", slp, 1);
    chk("R1 clr", clr, 0);
    chk("R1 drop", drp, 0);
    rst = 1'b0;
    cycles(1);
    chk("R1 en after release", en, 0);
    chk("R7 sleep after release", slp, 1);

    for (int i = 0; i < NV; i++) begin
      raw = VECS[i].lvl;
      cycles(int'(VECS[i].cyc));
      chk("R2-R5 vector en", en, int'(VECS[i].en));
      chk("R7 vector sleep", slp, int'(!VECS[i].en));
      chk("R6 clr count", nclr, int'(VECS[i].nclr));
      chk("R8 drop count", ndrop, int'(VECS[i].ndrop));
    end

    // R3 exact rise latency
    raw = 1'b1;
    cycles(RISE + 2);
    chk("R3 one edge early", en, 0);
    cycles(1);
    chk("R3 on time", en, 1);
    chk("R6 clr with rise", clr, 1);
    cycles(20);

    // R9 reset while raw high, requalify
    rst = 1'b1;
    cycles(2);
    chk("R1 en in reset", en, 0);
    chk("R1 sleep in reset", slp, 1);
    rst = 1'b0;
    cycles(RISE + 2);
    chk("R9 still low", en, 0);
    cycles(1);
    chk("R9 requalified", en, 1);
    chk("R9 clr", clr, 1);
    cycles(5);

    // R5 exact fall latency
    raw = 1'b0;
    cycles(FALL + 2);
    chk("R5 one edge early", en, 1);
    cycles(1);
    chk("R5 on time", en, 0);
    chk("R8 drop with fall", drp, 1);
    chk("R7 sleep at fall", slp, 1);
    cycles(3);
    chk("R8 drop total", ndrop, 4);
    chk("R6 clr total", nclr, 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule